// File: doc/BRIEF.md
# Processor Time Base and Timer Events

This block is the timer facility of one processor core. It keeps a 64-bit time base that only counts up, and a 32-bit down-counter that can reload itself from a stored value. Both advance on a shared tick. The tick comes either from the system clock divided by eight, or from a slow external real-time clock input that is synchronized into the system clock domain and edge-detected. A level enable gates all counting.

Two event channels watch the time base. One is a fixed-interval channel and the other is a watchdog channel. Each channel picks one time-base bit with a 6-bit index, made of a 2-bit coarse field above a 4-bit fine field, and pulses when counting drives that bit from 0 to 1. The down-counter pulses when it counts from 1 to 0. Software-style write ports load either time-base half, the down-counter and the reload value. A write wins over a tick in the same cycle and never produces an event.

Top module: `core_timer_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `tb_value`, `dec_value` and `reload_value` read 0 and all three event outputs are low.
- R2: With `tick_sel`=0 and `count_en` high, the tick is the system clock divided by eight, so `tb_value` rises by exactly 1 every 8 clock cycles.
- R3: With `tick_sel`=1, `tb_value` rises by 1 for each rising edge of `rtc_in`, which must run slower than half the clock rate. The divided clock has no effect in this mode.
- R4: While `count_en` is low, `tb_value` and `dec_value` hold their values.
- R5: `tb_hi_we` loads `tb_wdata` into bits 63:32 of the time base and `tb_lo_we` loads it into bits 31:0. The other half is left as it was. A write in the same cycle as a tick suppresses the increment.
- R6: Each enabled tick lowers `dec_value` by 1. From 0 it wraps to 32'hFFFFFFFF with no event.
- R7: If `reload_en` is high when a tick takes `dec_value` from 1, the counter loads `reload_value` instead. `dec_evt` is high for exactly one cycle, the same cycle in which the new value first appears.
- R8: If `reload_en` is low, a tick takes `dec_value` from 1 to 0 and `dec_evt` pulses for one cycle.
- R9: `fit_evt` pulses for one cycle when a counting step moves time-base bit (63 − {`fit_base`,`fit_ext`}) from 0 to 1. Index 0 is bit 63 and index 63 is bit 0. The pulse appears in the cycle in which `tb_value` first shows the new value.
- R10: `wd_evt` behaves the same way on the bit chosen by {`wd_base`,`wd_ext`}, independent of the fixed-interval selection.
- R11: A write to the time base never raises `fit_evt` or `wd_evt`, and a write to the down-counter never raises `dec_evt`, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_in | input | 1 | External real-time clock, asynchronous |
| tick_sel | input | 1 | Tick source: 0 = clock/8, 1 = real-time clock |
| count_en | input | 1 | Enables time-base and down-counter counting |
| tb_hi_we | input | 1 | Write strobe for the time-base upper half |
| tb_lo_we | input | 1 | Write strobe for the time-base lower half |
| tb_wdata | input | 32 | Time-base write data |
| dec_we | input | 1 | Down-counter write strobe |
| dec_wdata | input | 32 | Down-counter write data |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 32 | Reload register write data |
| reload_en | input | 1 | Enables automatic reload on expiry |
| fit_base | input | 2 | Fixed-interval index, upper 2 bits |
| fit_ext | input | 4 | Fixed-interval index, lower 4 bits |
| wd_base | input | 2 | Watchdog index, upper 2 bits |
| wd_ext | input | 4 | Watchdog index, lower 4 bits |
| tb_value | output | 64 | Current time base |
| dec_value | output | 32 | Current down-counter value |
| reload_value | output | 32 | Current reload value |
| fit_evt | output | 1 | Fixed-interval event pulse |
| wd_evt | output | 1 | Watchdog event pulse |
| dec_evt | output | 1 | Down-counter expiry pulse |

## Verification
Several properties are checked on every cycle. The counters hold while disabled. The time base only ever moves by +1 unless it was written. An expiry pulse lasts one cycle and comes only from a counted 1. Each event pulse matches a rise of its selected bit, and no event follows a time-base write. Other behaviour can only be shown by the bench's scenarios. These include the true tick rates of the two sources, that the reload value is the one loaded, the wrap through zero, and that every one of the 64 selection indices reaches the intended bit for both channels.

// File: rtl/ctu_pkg.sv
package ctu_pkg;

    localparam int TB_W   = 64;
    localparam int HALF_W = TB_W / 2;
    localparam int DEC_W  = 32;
    localparam int BASE_W = 2;
    localparam int EXT_W  = 4;
    localparam int IDX_W  = BASE_W + EXT_W;
    localparam int DIV_W  = 3;
    localparam int N_EVT  = 2;
    localparam int EVT_FIT = 0;
    localparam int EVT_WD  = 1;

    typedef enum logic {
        SRC_DIV = 1'b0,
        SRC_RTC = 1'b1
    } tick_src_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [EXT_W-1:0]  ext;
    } bit_sel_t;

    typedef struct packed {
        logic              hi_we;
        logic              lo_we;
        logic [HALF_W-1:0] data;
    } tb_wr_t;

    function automatic logic [IDX_W-1:0] sel_index(input bit_sel_t s);
        return {s.base, s.ext};
    endfunction

    // index 0 addresses the most significant time-base bit
    function automatic logic pick_bit(input logic [TB_W-1:0] v, input bit_sel_t s);
        logic [IDX_W-1:0] pos;
        pos = IDX_W'(TB_W - 1) - sel_index(s);
        return v[pos];
    endfunction

endpackage

// File: rtl/ctu_tick_gen.sv
module ctu_tick_gen
    import ctu_pkg::*;
#(
    parameter int DIV_LOG2 = DIV_W,
    parameter int SYNC_N   = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rtc_in,
    input  tick_src_e src,
    output logic      tick
);

    logic [DIV_LOG2-1:0] div_q;
    logic [SYNC_N:0]     rtc_sh;
    logic                tick_div;
    logic                tick_rtc;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            rtc_sh <= '0;
        end else begin
            div_q  <= div_q + DIV_LOG2'(1);
            rtc_sh <= {rtc_sh[SYNC_N-1:0], rtc_in};
        end
    end

    always_comb begin
        tick_div = &div_q;
        // top flop holds the previous synchronized level
        tick_rtc = rtc_sh[SYNC_N-1] & ~rtc_sh[SYNC_N];
        case (src)
            SRC_RTC: tick = tick_rtc;
            default: tick = tick_div;
        endcase
    end

endmodule

// File: rtl/ctu_time_base.sv
module ctu_time_base
    import ctu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  tb_wr_t          wr,
    input  logic            adv,
    output logic [TB_W-1:0] tb_q,
    output logic [TB_W-1:0] tb_nxt,
    output logic            stepped
);

    always_comb begin
        tb_nxt  = tb_q + TB_W'(1);
        stepped = adv & ~(wr.hi_we | wr.lo_we);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_q <= '0;
        end else begin
            if (wr.hi_we) tb_q[TB_W-1:HALF_W] <= wr.data;
            if (wr.lo_we) tb_q[HALF_W-1:0]    <= wr.data;
            if (stepped)  tb_q                <= tb_nxt;
        end
    end

endmodule

// File: rtl/ctu_edge_evt.sv
module ctu_edge_evt
    import ctu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic [TB_W-1:0] tb_cur,
    input  logic [TB_W-1:0] tb_nxt,
    input  bit_sel_t        sel,
    output logic            evt
);

    logic bit_now;
    logic bit_new;

    always_comb begin
        bit_now = pick_bit(tb_cur, sel);
        bit_new = pick_bit(tb_nxt, sel);
    end

    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= step & ~bit_now & bit_new;
    end

endmodule

// File: rtl/ctu_decrementer.sv
module ctu_decrementer
    import ctu_pkg::*;
#(
    parameter int W = DEC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         dec_we,
    input  logic [W-1:0] dec_wdata,
    input  logic         rld_we,
    input  logic [W-1:0] rld_wdata,
    input  logic         rld_en,
    output logic [W-1:0] dec_q,
    output logic [W-1:0] rld_q,
    output logic         evt
);

    logic         step;
    logic         expire;
    logic [W-1:0] dec_d;

    always_comb begin
        step   = adv & ~dec_we;
        expire = step && (dec_q == W'(1));
        if (expire) dec_d = rld_en ? rld_q : '0;
        else        dec_d = dec_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
            rld_q <= '0;
            evt   <= 1'b0;
        end else begin
            if (dec_we)    dec_q <= dec_wdata;
            else if (step) dec_q <= dec_d;
            if (rld_we)    rld_q <= rld_wdata;
            evt <= expire;
        end
    end

endmodule

// File: rtl/core_timer_unit.sv
module core_timer_unit
    import ctu_pkg::*;
#(
    parameter int DIV_LOG2 = DIV_W,
    parameter int SYNC_N   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rtc_in,
    input  logic                tick_sel,
    input  logic                count_en,
    input  logic                tb_hi_we,
    input  logic                tb_lo_we,
    input  logic [HALF_W-1:0]   tb_wdata,
    input  logic                dec_we,
    input  logic [DEC_W-1:0]    dec_wdata,
    input  logic                reload_we,
    input  logic [DEC_W-1:0]    reload_wdata,
    input  logic                reload_en,
    input  logic [BASE_W-1:0]   fit_base,
    input  logic [EXT_W-1:0]    fit_ext,
    input  logic [BASE_W-1:0]   wd_base,
    input  logic [EXT_W-1:0]    wd_ext,
    output logic [TB_W-1:0]     tb_value,
    output logic [DEC_W-1:0]    dec_value,
    output logic [DEC_W-1:0]    reload_value,
    output logic                fit_evt,
    output logic                wd_evt,
    output logic                dec_evt
);

    logic            tick;
    logic            adv;
    tb_wr_t          tb_wr;
    logic [TB_W-1:0] tb_nxt;
    logic            tb_step;
    bit_sel_t        sel [N_EVT];
    logic [N_EVT-1:0] evt;

    ctu_tick_gen #(.DIV_LOG2(DIV_LOG2), .SYNC_N(SYNC_N)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .rtc_in (rtc_in),
        .src    (tick_src_e'(tick_sel)),
        .tick   (tick)
    );

    assign adv   = tick & count_en;
    assign tb_wr = '{hi_we: tb_hi_we, lo_we: tb_lo_we, data: tb_wdata};

    ctu_time_base u_tb (
        .clk     (clk),
        .rst     (rst),
        .wr      (tb_wr),
        .adv     (adv),
        .tb_q    (tb_value),
        .tb_nxt  (tb_nxt),
        .stepped (tb_step)
    );

    assign sel[EVT_FIT] = '{base: fit_base, ext: fit_ext};
    assign sel[EVT_WD]  = '{base: wd_base,  ext: wd_ext};

    generate
        for (genvar g = 0; g < N_EVT; g++) begin : g_evt
            ctu_edge_evt u_evt (
                .clk    (clk),
                .rst    (rst),
                .step   (tb_step),
                .tb_cur (tb_value),
                .tb_nxt (tb_nxt),
                .sel    (sel[g]),
                .evt    (evt[g])
            );
        end
    endgenerate

    assign fit_evt = evt[EVT_FIT];
    assign wd_evt  = evt[EVT_WD];

    ctu_decrementer #(.W(DEC_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .dec_we    (dec_we),
        .dec_wdata (dec_wdata),
        .rld_we    (reload_we),
        .rld_wdata (reload_wdata),
        .rld_en    (reload_en),
        .dec_q     (dec_value),
        .rld_q     (reload_value),
        .evt       (dec_evt)
    );

endmodule

// File: rtl/ctu_checker.sv
module ctu_checker
    import ctu_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                count_en,
    input logic                tb_hi_we,
    input logic                tb_lo_we,
    input logic                dec_we,
    input logic [BASE_W-1:0]   fit_base,
    input logic [EXT_W-1:0]    fit_ext,
    input logic [BASE_W-1:0]   wd_base,
    input logic [EXT_W-1:0]    wd_ext,
    input logic [TB_W-1:0]     tb_value,
    input logic [DEC_W-1:0]    dec_value,
    input logic                fit_evt,
    input logic                wd_evt,
    input logic                dec_evt
);

    bit_sel_t fit_sel;
    bit_sel_t wd_sel;
    logic     fit_bit;
    logic     wd_bit;

    always_comb begin
        fit_sel = '{base: fit_base, ext: fit_ext};
        wd_sel  = '{base: wd_base,  ext: wd_ext};
        fit_bit = pick_bit(tb_value, fit_sel);
        wd_bit  = pick_bit(tb_value, wd_sel);
    end

    // R4
    tb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(count_en) && !$past(tb_hi_we) && !$past(tb_lo_we)) |-> $stable(tb_value));

    // R4
    dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(count_en) && !$past(dec_we)) |-> $stable(dec_value));

    // R2
    tb_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(tb_hi_we) && !$past(tb_lo_we) && (tb_value != $past(tb_value)))
        |-> (tb_value == $past(tb_value) + TB_W'(1)));

    // R7
    dec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dec_evt |=> !dec_evt);

    // R8
    dec_from_one_chk: assert property (@(posedge clk) disable iff (rst)
        dec_evt |-> ($past(dec_value) == DEC_W'(1)) && !$past(dec_we));

    // R9
    fit_rise_chk: assert property (@(posedge clk) disable iff (rst)
        fit_evt |-> (pick_bit(tb_value, $past(fit_sel)) && !$past(fit_bit)));

    // R10
    wd_rise_chk: assert property (@(posedge clk) disable iff (rst)
        wd_evt |-> (pick_bit(tb_value, $past(wd_sel)) && !$past(wd_bit)));

    // R11
    no_evt_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(tb_hi_we) || $past(tb_lo_we)) |-> (!fit_evt && !wd_evt));

endmodule

bind core_timer_unit ctu_checker u_chk (.*);

// File: tb/tb_core_timer_unit.sv
module tb_core_timer_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        rtc_in, tick_sel, count_en;
    logic        tb_hi_we, tb_lo_we;
    logic [31:0] tb_wdata;
    logic        dec_we, reload_we, reload_en;
    logic [31:0] dec_wdata, reload_wdata;
    logic [1:0]  fit_base, wd_base;
    logic [3:0]  fit_ext, wd_ext;
    logic [63:0] tb_value;
    logic [31:0] dec_value, reload_value;
    logic        fit_evt, wd_evt, dec_evt;

    int checks = 0;
    int errs   = 0;

    core_timer_unit dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_tb(input logic [63:0] v);
        tb_hi_we = 1'b1; tb_wdata = v[63:32]; step(1);
        tb_hi_we = 1'b0; tb_lo_we = 1'b1; tb_wdata = v[31:0]; step(1);
        tb_lo_we = 1'b0;
    endtask

    task automatic wr_dec(input logic [31:0] v);
        dec_we = 1'b1; dec_wdata = v; step(1); dec_we = 1'b0;
    endtask

    task automatic wr_rld(input logic [31:0] v);
        reload_we = 1'b1; reload_wdata = v; step(1); reload_we = 1'b0;
    endtask

    function automatic logic [31:0] dec_model(input logic [31:0] d, input logic [31:0] rl,
                                              input bit ren, input int n);
        logic [31:0] x = d;
        for (int i = 0; i < n; i++) x = (x == 32'd1) ? (ren ? rl : 32'd0) : x - 32'd1;
        return x;
    endfunction

    task automatic t_reset;
        chk(tb_value == 0, "R1 tb", tb_value, 0);
        chk(dec_value == 0 && reload_value == 0, "R1 dec/reload", {dec_value, reload_value}, 0);
        chk({fit_evt, wd_evt, dec_evt} == 0, "R1 events", {fit_evt, wd_evt, dec_evt}, 0);
    endtask

    task automatic t_div8;
        int c;
        tick_sel = 1'b0; count_en = 1'b0; wr_tb(64'd0); count_en = 1'b1;
        c = 0;
        while (tb_value == 0 && c < 20) begin step(1); c++; end
        chk(tb_value == 1, "R2 first tick", tb_value, 1);
        c = 0;
        while (tb_value == 1 && c < 20) begin step(1); c++; end
        chk(c == 8, "R2 period", c, 8);
        chk(tb_value == 2, "R2 increment", tb_value, 2);
        count_en = 1'b0;
    endtask

    task automatic t_rtc;
        tick_sel = 1'b1; count_en = 1'b0; wr_tb(64'd0); count_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            rtc_in = 1'b1; step(3); rtc_in = 1'b0; step(3);
        end
        step(4);
        chk(tb_value == 5, "R3 rtc edges", tb_value, 5);
        step(24);
        chk(tb_value == 5, "R3 divider ignored", tb_value, 5);
        count_en = 1'b0; tick_sel = 1'b0;
    endtask

    task automatic t_enable;
        logic [63:0] t0; logic [31:0] d0;
        count_en = 1'b0; reload_en = 1'b0;
        wr_dec(32'd9); wr_tb(64'h55);
        t0 = tb_value; d0 = dec_value; step(30);
        chk(tb_value == t0, "R4 tb hold", tb_value, t0);
        chk(dec_value == d0, "R4 dec hold", dec_value, d0);
    endtask

    task automatic t_writes;
        count_en = 1'b0;
        wr_tb({32'hAAAA0000, 32'h00001234});
        chk(tb_value == {32'hAAAA0000, 32'h00001234}, "R5 both halves", tb_value, {32'hAAAA0000, 32'h00001234});
        tb_hi_we = 1'b1; tb_wdata = 32'hDEAD0000; step(1); tb_hi_we = 1'b0;
        chk(tb_value == {32'hDEAD0000, 32'h00001234}, "R5 upper only", tb_value, {32'hDEAD0000, 32'h00001234});
        tb_lo_we = 1'b1; tb_wdata = 32'h00000077; step(1); tb_lo_we = 1'b0;
        chk(tb_value == {32'hDEAD0000, 32'h00000077}, "R5 lower only", tb_value, {32'hDEAD0000, 32'h00000077});
        tick_sel = 1'b0; count_en = 1'b1;
        tb_lo_we = 1'b1; tb_wdata = 32'h100; step(20);
        chk(tb_value == {32'hDEAD0000, 32'h00000100}, "R5 write beats tick", tb_value, {32'hDEAD0000, 32'h00000100});
        tb_lo_we = 1'b0; count_en = 1'b0;
    endtask

    task automatic t_dec_count;
        count_en = 1'b0; reload_en = 1'b0;
        wr_tb(64'd0); wr_dec(32'd20);
        count_en = 1'b1; step(50); count_en = 1'b0; step(1);
        chk(dec_value == 32'd20 - tb_value[31:0], "R6 count down", dec_value, 32'd20 - tb_value[31:0]);
    endtask

    task automatic t_dec_reload(input bit ren, input logic [31:0] start, input int cyc, input string req);
        int n = 0; bit prev = 0; bit dbl = 0; logic [31:0] at = '1; logic [31:0] expv;
        count_en = 1'b0; reload_en = ren;
        wr_rld(32'd7); wr_dec(start); wr_tb(64'd0);
        count_en = 1'b1;
        for (int i = 0; i < cyc; i++) begin
            step(1);
            if (dec_evt) begin n++; at = dec_value; if (prev) dbl = 1; end
            prev = dec_evt;
        end
        count_en = 1'b0; step(1);
        expv = ren ? 32'd7 : 32'd0;
        chk(n == 1, {req, " one event"}, n, 1);
        chk(!dbl, {req, " pulse width"}, dbl, 0);
        chk(at == expv, {req, " value at event"}, at, expv);
        chk(dec_value == dec_model(start, 32'd7, ren, int'(tb_value[31:0])), {req, " final value"},
            dec_value, dec_model(start, 32'd7, ren, int'(tb_value[31:0])));
    endtask

    task automatic t_sel(input bit wd_chan);
        for (int idx = 0; idx < 64; idx++) begin
            logic [5:0] a = 6'(idx); logic [5:0] b = 6'(idx) ^ 6'd32;
            logic [63:0] v = (64'd1 << (63 - idx)) - 64'd1;
            logic [63:0] at = '0; int nh = 0; int no = 0;
            count_en = 1'b0; tick_sel = 1'b0;
            if (wd_chan) begin {wd_base, wd_ext} = a; {fit_base, fit_ext} = b; end
            else         begin {fit_base, fit_ext} = a; {wd_base, wd_ext} = b; end
            wr_tb(v);
            count_en = 1'b1;
            for (int i = 0; i < 12; i++) begin
                step(1);
                if (wd_chan ? wd_evt : fit_evt) begin nh++; at = tb_value; end
                if (wd_chan ? fit_evt : wd_evt) no++;
            end
            count_en = 1'b0;
            if (wd_chan) begin
                chk(nh == 1, "R10 wd event count", nh, 1);
                chk(at == v + 1, "R10 wd event bit", at, v + 1);
                chk(no == 0, "R10 fit channel quiet", no, 0);
            end else begin
                chk(nh == 1, "R9 fit event count", nh, 1);
                chk(at == v + 1, "R9 fit event bit", at, v + 1);
                chk(no == 0, "R9 wd channel quiet", no, 0);
            end
        end
    endtask

    task automatic t_write_quiet;
        int n = 0;
        count_en = 1'b0;
        {fit_base, fit_ext} = 6'd63; {wd_base, wd_ext} = 6'd62;
        wr_tb(64'd0);
        fork
            begin wr_tb(64'd3); wr_dec(32'd5); wr_dec(32'd1); wr_dec(32'd0); step(3); end
            begin repeat (12) begin @(negedge clk); if (fit_evt || wd_evt || dec_evt) n++; end end
        join
        chk(n == 0, "R11 writes raise no event", n, 0);
        chk(tb_value == 64'd3, "R11 tb written", tb_value, 3);
        chk(dec_value == 32'd0, "R11 dec written", dec_value, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; rtc_in = 1'b0; tick_sel = 1'b0; count_en = 1'b0;
        tb_hi_we = 1'b0; tb_lo_we = 1'b0; tb_wdata = '0;
        dec_we = 1'b0; dec_wdata = '0; reload_we = 1'b0; reload_wdata = '0; reload_en = 1'b0;
        fit_base = '0; fit_ext = '0; wd_base = '0; wd_ext = '0;
        step(4);
        t_reset;
        rst = 1'b0; step(1);
        t_reset;
        t_div8;
        t_rtc;
        t_enable;
        t_writes;
        t_dec_count;
        t_dec_reload(1'b1, 32'd3, 45, "R7");
        t_dec_reload(1'b0, 32'd2, 35, "R8");
        t_sel(1'b0);
        t_sel(1'b1);
        t_write_quiet;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule